// File: doc/BRIEF.md
# Line Signal Quality Monitor

This block judges the health of a serial line from a stream of per-symbol error strobes produced by an upstream decoder. Time is cut into fixed windows of `WINDOW_CYCLES` clock cycles. At each window boundary a saturating up-down counter moves one step: up if the window saw any bad symbol, down if it saw none. The counter value is therefore a short memory of how many recent windows were dirty.

A good-line status bit is derived from that counter with hysteresis. It turns on only when the counter hits its floor and turns off only when it hits its ceiling, so a flip in either direction needs a run of qualifying windows (seven with the default 3-bit counter). Every flip of the status bit raises a sticky interrupt flag, which stays set until the clear input is pulsed. The clear input stands in for software reading a status register. The counter value is brought out for debug.

Top module: `line_quality_mon`

## Requirements
- R1: While reset is held and right after it is released, the window counter reads its maximum (7 for a 3-bit counter), the good bit reads 0 and the interrupt flag reads 0.
- R2: A window is `WINDOW_CYCLES` clock cycles long. The first window ends on the `WINDOW_CYCLES`-th rising edge after reset is released, and the counter output changes only on window-ending edges.
- R3: At the end of a window with no bad-symbol strobe, the counter decreases by one, and it stays at 0 when it is already 0.
- R4: At the end of a window with at least one bad-symbol strobe, the counter increases by one, and it stays at its maximum when it is already at the maximum.
- R5: Any number of strobes in one window moves the counter by exactly one step.
- R6: A strobe on the last cycle of a window counts toward that window. A strobe on the first cycle of a window counts toward the new window only.
- R7: The good bit becomes 1 on the same edge at which the counter becomes 0. It becomes 0 on the same edge at which the counter becomes its maximum. For any other counter value it keeps its last value.
- R8: Any change of the good bit sets the interrupt flag on that same edge. The flag then stays set until a cycle with the clear input high, after which it reads 0.
- R9: If the good bit changes on the same edge at which the clear input is high, the interrupt flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bad_sym_i | input | 1 | One-cycle strobe per bad symbol detected by the decoder |
| irq_clr_i | input | 1 | Clears the interrupt flag (acts as a status read) |
| good_o | output | 1 | Line status: 1 = good, 0 = bad |
| irq_o | output | 1 | Sticky flag set on any change of `good_o` |
| win_cnt_o | output | CNT_W | Current value of the window counter, for debug |

## Verification
All results appear on the window-ending edge: the counter, the good bit and the interrupt are registered in the same cycle. So counter, good bit and interrupt are due one full window after the first cycle of that window, and the bench samples them on the falling edge right after that edge. An extra sample one cycle before the boundary confirms that the counter has not moved yet. The result of a mid-window clear is due on the next edge and is sampled on the following falling edge. The bench runs a short window (8 cycles) and drives strobes at the first and last positions, so the boundary cases sit exactly on the edges being sampled.

// File: rtl/lqm_pkg.sv
// Shared helpers for the line quality monitor.
// Assumes counters are unsigned and that the saturation bounds fit the width.
package lqm_pkg;

    // One saturating step up or down of an unsigned counter of width 8 or less.
    function automatic logic [7:0] sat_step(input logic [7:0] cur,
                                            input logic       up,
                                            input logic [7:0] top);
        logic [7:0] nxt;
        if (up) begin
            nxt = (cur >= top) ? top : cur + 8'd1;
        end else begin
            nxt = (cur == 8'd0) ? 8'd0 : cur - 8'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/lqm_window_timer.sv
// Window timer: counts clock cycles and flags the last cycle of each window.
// Assumes WINDOW_CYCLES >= 2; the timer restarts from zero after reset.
module lqm_window_timer #(
    parameter int WINDOW_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_end_o
);
    localparam int TW = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(WINDOW_CYCLES - 1);

    logic [TW-1:0] tmr_q;

    // Last cycle of the window is flagged combinationally.
    assign win_end_o = (tmr_q == LAST);

    // Advance the cycle count and wrap at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (win_end_o) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_end_o |=> (tmr_q == '0));

endmodule

// File: rtl/lqm_error_latch.sv
// Error latch: remembers whether any bad-symbol strobe arrived in the window.
// A strobe on the last cycle still counts toward that window.
module lqm_error_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic bad_sym_i,
    input  logic win_end_i,
    output logic had_err_o
);
    logic seen_q;

    // Window had errors if a strobe was latched earlier or arrives now.
    assign had_err_o = seen_q | bad_sym_i;

    // Set on any strobe, cleared at each window boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (win_end_i) begin
            seen_q <= 1'b0;
        end else if (bad_sym_i) begin
            seen_q <= 1'b1;
        end
    end

    // R6
    boundary_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_end_i |=> !seen_q);

    // R5
    stays_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !win_end_i) |=> seen_q);

endmodule

// File: rtl/lqm_updown.sv
// Saturating up-down window counter: one step per window end.
// Steps up after an error window and down after a clean one; resets to the top value.
module lqm_updown #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_end_i,
    input  logic             had_err_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_d_o
);
    import lqm_pkg::*;

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       step;

    // Next value: one saturating step at a window end, hold otherwise.
    always_comb begin
        step    = sat_step(8'(cnt_q), had_err_i, 8'(TOP));
        cnt_d_o = win_end_i ? step[CNT_W-1:0] : cnt_q;
    end

    // Register the counter; reset to the top value (line presumed bad).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= TOP;
        end else begin
            cnt_q <= cnt_d_o;
        end
    end

    assign cnt_q_o = cnt_q;

    // R2
    hold_mid_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end_i |=> $stable(cnt_q));

    // R4
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end_i && had_err_i && cnt_q == TOP) |=> (cnt_q == TOP));

    // R3
    sat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end_i && !had_err_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/lqm_status.sv
// Status and interrupt: hysteretic good bit from the counter's next value,
// and a sticky change flag that a change wins over a simultaneous clear.
module lqm_status #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_d_i,
    input  logic             irq_clr_i,
    output logic             good_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic good_q;
    logic good_d;
    logic irq_q;

    // Set at the floor, clear at the top, hold in between.
    always_comb begin
        if (cnt_d_i == '0) begin
            good_d = 1'b1;
        end else if (cnt_d_i == TOP) begin
            good_d = 1'b0;
        end else begin
            good_d = good_q;
        end
    end

    // Register the status bit; starts as bad.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_q <= 1'b0;
        end else begin
            good_q <= good_d;
        end
    end

    // Sticky interrupt: a change sets it (priority), a clear drops it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (good_d != good_q) begin
            irq_q <= 1'b1;
        end else if (irq_clr_i) begin
            irq_q <= 1'b0;
        end
    end

    assign good_o = good_q;
    assign irq_o  = irq_q;

    // R8
    irq_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good_q != $past(good_q)) |-> irq_q);

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clr_i) |=> irq_q);

endmodule

// File: rtl/line_quality_mon.sv
// Line quality monitor top: window timer, error latch, window counter and
// status/interrupt logic. Assumes bad_sym_i and irq_clr_i are synchronous to clk.
module line_quality_mon #(
    parameter int WINDOW_CYCLES = 1024,
    parameter int CNT_W         = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bad_sym_i,
    input  logic             irq_clr_i,
    output logic             good_o,
    output logic             irq_o,
    output logic [CNT_W-1:0] win_cnt_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic             win_end;
    logic             had_err;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    lqm_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_end_o (win_end)
    );

    lqm_error_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .bad_sym_i (bad_sym_i),
        .win_end_i (win_end),
        .had_err_o (had_err)
    );

    lqm_updown #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_end_i (win_end),
        .had_err_i (had_err),
        .cnt_q_o   (cnt_q),
        .cnt_d_o   (cnt_d)
    );

    lqm_status #(.CNT_W(CNT_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_d_i   (cnt_d),
        .irq_clr_i (irq_clr_i),
        .good_o    (good_o),
        .irq_o     (irq_o)
    );

    assign win_cnt_o = cnt_q;

    // R7
    good_at_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> good_o);

    // R7
    bad_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP) |-> !good_o);

    // R9
    change_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_i && (good_o != $past(good_o))) |-> irq_o);

endmodule

// File: tb/line_quality_mon_bench.sv
module line_quality_mon_bench;
    localparam int W    = 8;
    localparam int TOPV = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bad_sym = 1'b0;
    logic       irq_clr = 1'b0;
    logic       good;
    logic       irq;
    logic [2:0] cnt;

    int errors = 0;
    int total  = 0;
    int exp_cnt  = TOPV;
    int exp_good = 0;
    int exp_irq  = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    line_quality_mon #(.WINDOW_CYCLES(W), .CNT_W(3)) u_line_quality_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .bad_sym_i (bad_sym),
        .irq_clr_i (irq_clr),
        .good_o    (good),
        .irq_o     (irq),
        .win_cnt_o (cnt)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One full window from a falling edge. Strobes at positions a and b,
    // clear at position c (-1 = none). Model follows R3..R9 arithmetically.
    task automatic run_window(input string req, input int a, input int b, input int c);
        bit had = 1'b0;
        bit clr_seen = 1'b0;
        int old_good;
        for (int i = 0; i < W; i++) begin
            bad_sym = (i == a) || (i == b);
            irq_clr = (i == c);
            if (bad_sym) had = 1'b1;
            if (irq_clr) clr_seen = 1'b1;
            @(posedge clk);
            @(negedge clk);
            if (i == W - 2) check("R2", "cnt before boundary", int'(cnt), exp_cnt);
            if (i == c && i < W - 1) check("R8", "irq after clear", int'(irq), 0);
        end
        bad_sym = 1'b0;
        irq_clr = 1'b0;
        exp_cnt  = had ? ((exp_cnt >= TOPV) ? TOPV : exp_cnt + 1)
                       : ((exp_cnt == 0) ? 0 : exp_cnt - 1);
        old_good = exp_good;
        if (exp_cnt == 0)    exp_good = 1;
        if (exp_cnt == TOPV) exp_good = 0;
        if (exp_good != old_good) exp_irq = 1;
        else if (clr_seen)        exp_irq = 0;
        check(req, "cnt", int'(cnt), exp_cnt);
        check("R7", "good", int'(good), exp_good);
        check((exp_good != old_good && c == W - 1) ? "R9" : "R8", "irq", int'(irq), exp_irq);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1", "cnt in reset", int'(cnt), TOPV);
        check("R1", "good in reset", int'(good), 0);
        check("R1", "irq in reset", int'(irq), 0);
        rst_n = 1'b1;
        // R1 right after release
        check("R1", "cnt after release", int'(cnt), TOPV);

        for (int k = 0; k < 6; k++) run_window("R3", -1, -1, -1);   // 6..1
        run_window("R4", 3, -1, -1);                                 // 2
        run_window("R5", 1, 5, -1);                                  // 3, one step only
        for (int k = 0; k < 3; k++) run_window("R3", -1, -1, -1);   // 2,1,0 good
        run_window("R3", -1, -1, -1);                                // floor saturates
        run_window("R8", -1, -1, 2);                                 // mid-window clear
        run_window("R6", W - 1, -1, -1);                             // last cycle counts
        run_window("R6", 0, -1, -1);                                 // first cycle counts
        for (int k = 0; k < 5; k++) run_window("R4", (k % 2 == 0) ? W - 1 : 0, -1, -1);
        run_window("R4", 2, -1, -1);                                 // top saturates
        for (int k = 0; k < 6; k++) run_window("R7", -1, -1, -1);   // hold at bad
        run_window("R9", -1, -1, W - 1);                             // change vs clear
        run_window("R8", -1, -1, W - 1);                             // plain clear

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, total);
            $finish;
        end
    end

endmodule